// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address by reading a two-level translation tree out of memory. A requester hands over one virtual address at a time, together with a flag that says whether the access is a store. The walker reads the directory entry, then the leaf entry, and answers with either the physical address or a fault that carries a cause code and the virtual address that failed.

The directory base is a page number held in a register inside the block. It is loaded through a write strobe, and each walk takes a snapshot of it when the request is accepted. When a translation succeeds, the walker keeps the accessed and dirty flags of the leaf entry current. It writes the entry back to the same memory word only if one of these flags changes.

Both the request/response side and the memory side use valid/ready handshakes. Read data comes back on a separate valid strobe, and only one translation is in flight at any time.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_valid_o is 0 and mem_valid_o is 0, and the held directory base page number is 0.
- R2: The first memory access of a walk is a read at {root, va[31:22], 2'b00}. Here root is the base page number loaded through root_we_i/root_ppn_i before the request was accepted.
- R3: The second access is a read at {dir_entry[31:12], va[21:12], 2'b00}. An entry keeps its base page number in bits 31:12.
- R4: A walk that succeeds answers with rsp_fault_o=0 and rsp_paddr_o={leaf_entry[31:12], va[11:0]}. The page offset passes through unchanged.
- R5: A directory entry whose present flag (bit 0) is 0 ends the walk with rsp_fault_o=1 and rsp_cause_o=0 after exactly one memory read. All other bits of that entry are ignored.
- R6: A leaf entry whose present flag is 0 ends the walk with rsp_cause_o=1 and no write to memory. All other bits of that entry are ignored.
- R7: A store to a page whose leaf entry has writable flag (bit 1) 0 faults with rsp_cause_o=2 and no write to memory.
- R8: When a translation succeeds, the leaf entry gets accessed flag (bit 5) set on any access, and dirty flag (bit 6) set on a store. If either flag changes, the updated entry is written back to the leaf word, with all its other bits unchanged.
- R9: There is no write-back when the leaf already has the accessed flag set on a load, or both flags set on a store.
- R10: req_ready_o is 0 from the accepting edge until the response is taken. mem_valid_o and its address, write flag and data hold until mem_ready_i. rsp_valid_o and all response fields hold until rsp_ready_i.
- R11: A fault reports the failing virtual address on rsp_vaddr_o and drives rsp_paddr_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| root_we_i | input | 1 | Load strobe for the directory base register |
| root_ppn_i | input | 20 | Directory base page number |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_write_i | input | 1 | 1 for a store access, 0 for a load |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response taken |
| rsp_paddr_o | output | 32 | Physical address, 0 on fault |
| rsp_fault_o | output | 1 | Translation failed |
| rsp_cause_o | output | 2 | Fault cause: 0 directory absent, 1 leaf absent, 2 store to read-only |
| rsp_vaddr_o | output | 32 | Virtual address of this response |
| mem_valid_o | output | 1 | Memory access request |
| mem_ready_i | input | 1 | Memory access accepted |
| mem_we_o | output | 1 | 1 for a write-back, 0 for a read |
| mem_addr_o | output | 32 | Word address |
| mem_wdata_o | output | 32 | Write-back data |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |

## Verification
The assertions check the following properties on every cycle:
- requests, memory accesses and responses hold stable under back-pressure;
- a new request is never accepted while a walk is in flight;
- a faulting response carries a zero physical address and a legal cause;
- a successful response keeps the page offset;
- every write-back sets the accessed flag.

The directed scenarios cover the behaviour that depends on table contents:
- the exact directory and leaf addresses, and how a change of the root register affects them;
- the frame number returned;
- which walks write back, and with what word;
- that absent entries full of stray bits still fault with the right cause and stop after the right number of reads.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int unsigned PTE_W     = 32;
  localparam int unsigned PTE_PRES  = 0;
  localparam int unsigned PTE_WRBL  = 1;
  localparam int unsigned PTE_ACC   = 5;
  localparam int unsigned PTE_DIRTY = 6;

  typedef enum logic [1:0] {
    CAUSE_DIR_ABSENT  = 2'd0,
    CAUSE_LEAF_ABSENT = 2'd1,
    CAUSE_WR_RDONLY   = 2'd2
  } fault_cause_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_REQ,
    ST_DIR_WAIT,
    ST_LEAF_REQ,
    ST_LEAF_WAIT,
    ST_WB_REQ,
    ST_RESP
  } walk_state_e;
endpackage

// File: rtl/pt_root_reg.sv
module pt_root_reg #(
  parameter int unsigned PPN_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [PPN_W-1:0] ppn_i,
  output logic [PPN_W-1:0] ppn_o
);
  logic [PPN_W-1:0] ppn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ppn_q <= '0;
    else if (we_i) ppn_q <= ppn_i;
  end

  assign ppn_o = ppn_q;
endmodule

// File: rtl/pt_pte_decode.sv
module pt_pte_decode
  import pt_walker_pkg::*;
#(
  parameter int unsigned OFF_W = 12
) (
  input  logic [PTE_W-1:0]       pte_i,
  input  logic                   is_write_i,
  output logic                   present_o,
  output logic [PTE_W-OFF_W-1:0] base_o,
  output logic                   wr_fault_o,
  output logic                   need_wb_o,
  output logic [PTE_W-1:0]       upd_pte_o
);
  logic [PTE_W-1:0] set_mask;

  always_comb begin
    set_mask = '0;
    set_mask[PTE_ACC] = 1'b1;
    set_mask[PTE_DIRTY] = is_write_i;
  end

  assign present_o  = pte_i[PTE_PRES];
  assign base_o     = pte_i[PTE_W-1:OFF_W];
  assign wr_fault_o = present_o && is_write_i && !pte_i[PTE_WRBL];
  assign upd_pte_o  = pte_i | set_mask;
  // write back only when a flag actually flips
  assign need_wb_o  = present_o && !wr_fault_o && (upd_pte_o != pte_i);
endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walker_pkg::*;
#(
  parameter int unsigned OFF_W = 12,
  parameter int unsigned IDX_W = 10
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [PTE_W-OFF_W-1:0]   root_ppn_i,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic [OFF_W+2*IDX_W-1:0] req_vaddr_i,
  input  logic                     req_write_i,
  output logic                     rsp_valid_o,
  input  logic                     rsp_ready_i,
  output logic [PTE_W-1:0]         rsp_paddr_o,
  output logic                     rsp_fault_o,
  output logic [1:0]               rsp_cause_o,
  output logic [OFF_W+2*IDX_W-1:0] rsp_vaddr_o,
  output logic                     mem_valid_o,
  input  logic                     mem_ready_i,
  output logic                     mem_we_o,
  output logic [PTE_W-1:0]         mem_addr_o,
  output logic [PTE_W-1:0]         mem_wdata_o,
  input  logic                     mem_rvalid_i,
  output logic                     walk_write_o,
  input  logic                     pte_present_i,
  input  logic [PTE_W-OFF_W-1:0]   pte_base_i,
  input  logic                     pte_wr_fault_i,
  input  logic                     pte_need_wb_i,
  input  logic [PTE_W-1:0]         pte_upd_i
);
  localparam int unsigned VA_W   = OFF_W + 2*IDX_W;
  localparam int unsigned PPN_W  = PTE_W - OFF_W;
  localparam int unsigned SLOT_W = OFF_W - IDX_W;
  localparam int unsigned LEAF_LO = OFF_W;
  localparam int unsigned DIR_LO  = OFF_W + IDX_W;

  walk_state_e      state_q;
  fault_cause_e     cause_q;
  logic [VA_W-1:0]  va_q;
  logic             wr_q;
  logic             fault_q;
  logic [PPN_W-1:0] root_q;
  logic [PPN_W-1:0] tbl_q;
  logic [PPN_W-1:0] ppn_q;
  logic [PTE_W-1:0] wb_q;

  logic [IDX_W-1:0] dir_idx, leaf_idx;
  assign dir_idx  = va_q[DIR_LO +: IDX_W];
  assign leaf_idx = va_q[LEAF_LO +: IDX_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cause_q <= CAUSE_DIR_ABSENT;
      va_q    <= '0;
      wr_q    <= 1'b0;
      fault_q <= 1'b0;
      root_q  <= '0;
      tbl_q   <= '0;
      ppn_q   <= '0;
      wb_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          va_q    <= req_vaddr_i;
          wr_q    <= req_write_i;
          root_q  <= root_ppn_i;
          fault_q <= 1'b0;
          cause_q <= CAUSE_DIR_ABSENT;
          ppn_q   <= '0;
          state_q <= ST_DIR_REQ;
        end
        ST_DIR_REQ: if (mem_ready_i) state_q <= ST_DIR_WAIT;
        ST_DIR_WAIT: if (mem_rvalid_i) begin
          if (!pte_present_i) begin
            fault_q <= 1'b1;
            cause_q <= CAUSE_DIR_ABSENT;
            state_q <= ST_RESP;
          end else begin
            tbl_q   <= pte_base_i;
            state_q <= ST_LEAF_REQ;
          end
        end
        ST_LEAF_REQ: if (mem_ready_i) state_q <= ST_LEAF_WAIT;
        ST_LEAF_WAIT: if (mem_rvalid_i) begin
          if (!pte_present_i) begin
            fault_q <= 1'b1;
            cause_q <= CAUSE_LEAF_ABSENT;
            state_q <= ST_RESP;
          end else if (pte_wr_fault_i) begin
            fault_q <= 1'b1;
            cause_q <= CAUSE_WR_RDONLY;
            state_q <= ST_RESP;
          end else begin
            ppn_q   <= pte_base_i;
            wb_q    <= pte_upd_i;
            state_q <= pte_need_wb_i ? ST_WB_REQ : ST_RESP;
          end
        end
        ST_WB_REQ: if (mem_ready_i) state_q <= ST_RESP;
        ST_RESP:   if (rsp_ready_i) state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_addr_o = '0;
    unique case (state_q)
      ST_DIR_REQ:             mem_addr_o = {root_q, dir_idx, {SLOT_W{1'b0}}};
      ST_LEAF_REQ, ST_WB_REQ: mem_addr_o = {tbl_q, leaf_idx, {SLOT_W{1'b0}}};
      default:                mem_addr_o = '0;
    endcase
  end

  assign req_ready_o  = (state_q == ST_IDLE);
  assign mem_valid_o  = (state_q == ST_DIR_REQ) || (state_q == ST_LEAF_REQ) ||
                        (state_q == ST_WB_REQ);
  assign mem_we_o     = (state_q == ST_WB_REQ);
  assign mem_wdata_o  = wb_q;
  assign walk_write_o = wr_q;
  assign rsp_valid_o  = (state_q == ST_RESP);
  assign rsp_fault_o  = fault_q;
  assign rsp_cause_o  = cause_q;
  assign rsp_vaddr_o  = va_q;
  assign rsp_paddr_o  = fault_q ? '0 : {ppn_q, va_q[OFF_W-1:0]};
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int unsigned OFF_W = 12,
  parameter int unsigned IDX_W = 10
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     root_we_i,
  input  logic [PTE_W-OFF_W-1:0]   root_ppn_i,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic [OFF_W+2*IDX_W-1:0] req_vaddr_i,
  input  logic                     req_write_i,
  output logic                     rsp_valid_o,
  input  logic                     rsp_ready_i,
  output logic [PTE_W-1:0]         rsp_paddr_o,
  output logic                     rsp_fault_o,
  output logic [1:0]               rsp_cause_o,
  output logic [OFF_W+2*IDX_W-1:0] rsp_vaddr_o,
  output logic                     mem_valid_o,
  input  logic                     mem_ready_i,
  output logic                     mem_we_o,
  output logic [PTE_W-1:0]         mem_addr_o,
  output logic [PTE_W-1:0]         mem_wdata_o,
  input  logic                     mem_rvalid_i,
  input  logic [PTE_W-1:0]         mem_rdata_i
);
  localparam int unsigned PPN_W = PTE_W - OFF_W;

  logic [PPN_W-1:0] root_ppn;
  logic             walk_write;
  logic             pte_present, pte_wr_fault, pte_need_wb;
  logic [PPN_W-1:0] pte_base;
  logic [PTE_W-1:0] pte_upd;

  pt_root_reg #(.PPN_W(PPN_W)) u_root (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (root_we_i),
    .ppn_i  (root_ppn_i),
    .ppn_o  (root_ppn)
  );

  pt_pte_decode #(.OFF_W(OFF_W)) u_dec (
    .pte_i      (mem_rdata_i),
    .is_write_i (walk_write),
    .present_o  (pte_present),
    .base_o     (pte_base),
    .wr_fault_o (pte_wr_fault),
    .need_wb_o  (pte_need_wb),
    .upd_pte_o  (pte_upd)
  );

  pt_walk_ctrl #(.OFF_W(OFF_W), .IDX_W(IDX_W)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .root_ppn_i     (root_ppn),
    .req_valid_i    (req_valid_i),
    .req_ready_o    (req_ready_o),
    .req_vaddr_i    (req_vaddr_i),
    .req_write_i    (req_write_i),
    .rsp_valid_o    (rsp_valid_o),
    .rsp_ready_i    (rsp_ready_i),
    .rsp_paddr_o    (rsp_paddr_o),
    .rsp_fault_o    (rsp_fault_o),
    .rsp_cause_o    (rsp_cause_o),
    .rsp_vaddr_o    (rsp_vaddr_o),
    .mem_valid_o    (mem_valid_o),
    .mem_ready_i    (mem_ready_i),
    .mem_we_o       (mem_we_o),
    .mem_addr_o     (mem_addr_o),
    .mem_wdata_o    (mem_wdata_o),
    .mem_rvalid_i   (mem_rvalid_i),
    .walk_write_o   (walk_write),
    .pte_present_i  (pte_present),
    .pte_base_i     (pte_base),
    .pte_wr_fault_i (pte_wr_fault),
    .pte_need_wb_i  (pte_need_wb),
    .pte_upd_i      (pte_upd)
  );
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
  import pt_walker_pkg::*;
#(
  parameter int unsigned OFF_W = 12,
  parameter int unsigned IDX_W = 10
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     req_valid_i,
  input logic                     req_ready_o,
  input logic                     rsp_valid_o,
  input logic                     rsp_ready_i,
  input logic [PTE_W-1:0]         rsp_paddr_o,
  input logic                     rsp_fault_o,
  input logic [1:0]               rsp_cause_o,
  input logic [OFF_W+2*IDX_W-1:0] rsp_vaddr_o,
  input logic                     mem_valid_o,
  input logic                     mem_ready_i,
  input logic                     mem_we_o,
  input logic [PTE_W-1:0]         mem_addr_o,
  input logic [PTE_W-1:0]         mem_wdata_o
);
  assert_mem_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) &&
      $stable(mem_we_o) && $stable(mem_wdata_o));

  assert_rsp_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_paddr_o) &&
      $stable(rsp_fault_o) && $stable(rsp_cause_o) && $stable(rsp_vaddr_o));

  assert_single_walk_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !rsp_valid_o && !mem_valid_o);

  assert_busy_after_accept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);

  assert_fault_zero_pa_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o |-> rsp_paddr_o == '0);

  assert_offset_pass_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_fault_o |-> rsp_paddr_o[OFF_W-1:0] == rsp_vaddr_o[OFF_W-1:0]);

  assert_cause_legal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o |-> rsp_cause_o != 2'd3);

  assert_wb_marks_access_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && mem_we_o |-> mem_wdata_o[PTE_ACC] && mem_wdata_o[PTE_PRES]);
endmodule

bind pt_walker pt_walker_chk #(.OFF_W(OFF_W), .IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_ready_i (rsp_ready_i),
  .rsp_paddr_o (rsp_paddr_o),
  .rsp_fault_o (rsp_fault_o),
  .rsp_cause_o (rsp_cause_o),
  .rsp_vaddr_o (rsp_vaddr_o),
  .mem_valid_o (mem_valid_o),
  .mem_ready_i (mem_ready_i),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o)
);

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        root_we_i = 1'b0;
  logic [19:0] root_ppn_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_vaddr_i = '0;
  logic        req_write_i = 1'b0;
  logic        rsp_valid_o;
  logic        rsp_ready_i = 1'b0;
  logic [31:0] rsp_paddr_o;
  logic        rsp_fault_o;
  logic [1:0]  rsp_cause_o;
  logic [31:0] rsp_vaddr_o;
  logic        mem_valid_o;
  logic        mem_ready_i;
  logic        mem_we_o;
  logic [31:0] mem_addr_o;
  logic [31:0] mem_wdata_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk_i = ~clk_i;

  pt_walker dut (.*);

  // memory model: one-cycle read latency, optional alternating ready
  logic [31:0] mem_q [logic [31:0]];
  logic        stall_en = 1'b0;
  logic        tick = 1'b0;
  int          n_rd = 0, n_wr = 0;
  logic [31:0] rd_log [0:3];
  logic [31:0] wr_addr_q = '0, wr_data_q = '0;

  assign mem_ready_i = !stall_en || tick;

  always @(posedge clk_i) begin
    tick <= ~tick;
    mem_rvalid_i <= 1'b0;
    if (mem_valid_o && mem_ready_i) begin
      if (mem_we_o) begin
        mem_q[mem_addr_o] = mem_wdata_o;
        wr_addr_q = mem_addr_o;
        wr_data_q = mem_wdata_o;
        n_wr = n_wr + 1;
      end else begin
        mem_rvalid_i <= 1'b1;
        mem_rdata_i  <= mem_q.exists(mem_addr_o) ? mem_q[mem_addr_o] : 32'h0;
        rd_log[n_rd % 4] = mem_addr_o;
        n_rd = n_rd + 1;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load_root(input logic [19:0] ppn);
    @(negedge clk_i);
    root_we_i = 1'b1; root_ppn_i = ppn;
    @(negedge clk_i);
    root_we_i = 1'b0;
  endtask

  // one translation; results returned with read/write counts for this walk
  logic [31:0] r_pa, r_va;
  logic        r_fault;
  logic [1:0]  r_cause;
  int          r_nrd, r_nwr;
  logic [31:0] r_rd0, r_rd1;

  task automatic xlate(input logic [31:0] va, input logic wr, input int hold, input string tag);
    int rd0, wr0;
    rd0 = n_rd; wr0 = n_wr;
    @(negedge clk_i);
    req_vaddr_i = va; req_write_i = wr; req_valid_i = 1'b1;
    while (!req_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check({tag, " R10 busy after accept"}, {31'b0, req_ready_o}, 32'd0);
    while (!rsp_valid_o) @(negedge clk_i);
    r_pa = rsp_paddr_o; r_va = rsp_vaddr_o; r_fault = rsp_fault_o; r_cause = rsp_cause_o;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk_i);
      check({tag, " R10 rsp held valid"}, {31'b0, rsp_valid_o}, 32'd1);
      check({tag, " R10 rsp held paddr"}, rsp_paddr_o, r_pa);
    end
    rsp_ready_i = 1'b1;
    @(negedge clk_i);
    rsp_ready_i = 1'b0;
    r_nrd = n_rd - rd0; r_nwr = n_wr - wr0;
    r_rd0 = rd_log[rd0 % 4]; r_rd1 = rd_log[(rd0 + 1) % 4];
  endtask

  task automatic t_reset();
    check("R1 ready after reset", {31'b0, req_ready_o}, 32'd1);
    check("R1 no response after reset", {31'b0, rsp_valid_o}, 32'd0);
    check("R1 no memory access after reset", {31'b0, mem_valid_o}, 32'd0);
  endtask

  task automatic t_root_zero();
    // root register resets to page 0: va dir idx 0 reads address 0
    mem_q[32'h0000_0000] = 32'h0000_0000;
    xlate(32'h0000_0123, 1'b0, 0, "root0");
    check("R1 reset root gives dir read at 0", r_rd0, 32'h0000_0000);
    check("R5 absent dir cause", {30'b0, r_cause}, 32'd0);
  endtask

  task automatic t_read_first();
    xlate(32'h0040_3ABC, 1'b0, 0, "rd1");
    check("R2 dir address", r_rd0, 32'h0000_1004);
    check("R3 leaf address", r_rd1, 32'h0000_200C);
    check("R4 paddr", r_pa, 32'h0005_5ABC);
    check("R4 no fault", {31'b0, r_fault}, 32'd0);
    check("R8 one write-back", r_nwr, 1);
    check("R8 write-back addr", wr_addr_q, 32'h0000_200C);
    check("R8 write-back sets accessed only", wr_data_q, 32'h0005_5023);
  endtask

  task automatic t_read_again();
    xlate(32'h0040_3ABC, 1'b0, 2, "rd2");
    check("R9 no write-back when accessed set", r_nwr, 0);
    check("R4 paddr repeat", r_pa, 32'h0005_5ABC);
  endtask

  task automatic t_write_dirty();
    xlate(32'h0040_3FF0, 1'b1, 0, "wr1");
    check("R4 store paddr", r_pa, 32'h0005_5FF0);
    check("R8 store write-back", r_nwr, 1);
    check("R8 store sets dirty", wr_data_q, 32'h0005_5063);
    xlate(32'h0040_3000, 1'b1, 0, "wr2");
    check("R9 no write-back when both set", r_nwr, 0);
    check("R9 word unchanged", mem_q[32'h0000_200C], 32'h0005_5063);
  endtask

  task automatic t_read_only();
    xlate(32'h0040_4010, 1'b1, 0, "ro");
    check("R7 fault", {31'b0, r_fault}, 32'd1);
    check("R7 cause", {30'b0, r_cause}, 32'd2);
    check("R7 no write", r_nwr, 0);
    check("R11 fault vaddr", r_va, 32'h0040_4010);
    check("R11 fault paddr zero", r_pa, 32'h0);
    check("R7 entry untouched", mem_q[32'h0000_2010], 32'h0007_7001);
    xlate(32'h0040_4010, 1'b0, 0, "ro_rd");
    check("R4 load from read-only page", r_pa, 32'h0007_7010);
    check("R8 load on read-only sets accessed", wr_data_q, 32'h0007_7021);
  endtask

  task automatic t_leaf_absent();
    xlate(32'h0040_5678, 1'b1, 0, "leafnp");
    check("R6 fault", {31'b0, r_fault}, 32'd1);
    check("R6 cause", {30'b0, r_cause}, 32'd1);
    check("R6 two reads", r_nrd, 2);
    check("R6 no write", r_nwr, 0);
    check("R11 leaf fault vaddr", r_va, 32'h0040_5678);
  endtask

  task automatic t_dir_absent();
    xlate(32'h0080_0123, 1'b0, 1, "dirnp");
    check("R5 fault", {31'b0, r_fault}, 32'd1);
    check("R5 cause", {30'b0, r_cause}, 32'd0);
    check("R5 single read", r_nrd, 1);
    check("R5 dir address", r_rd0, 32'h0000_1008);
    check("R11 dir fault paddr zero", r_pa, 32'h0);
  endtask

  task automatic t_root_change();
    load_root(20'h00009);
    stall_en = 1'b1;
    xlate(32'h0040_3ABC, 1'b1, 3, "newroot");
    stall_en = 1'b0;
    check("R2 dir address after root load", r_rd0, 32'h0000_9004);
    check("R3 leaf address via new dir", r_rd1, 32'h0000_A00C);
    check("R4 paddr under stall", r_pa, 32'h0001_2ABC);
    check("R9 no write-back flags set", r_nwr, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    mem_q[32'h0000_1004] = 32'h0000_2001;
    mem_q[32'h0000_1008] = 32'hABCD_E0FE;
    mem_q[32'h0000_200C] = 32'h0005_5003;
    mem_q[32'h0000_2010] = 32'h0007_7001;
    mem_q[32'h0000_2014] = 32'hFFFF_F0FE;
    mem_q[32'h0000_9004] = 32'h0000_A001;
    mem_q[32'h0000_A00C] = 32'h0001_2063;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_root_zero();
    load_root(20'h00001);
    t_read_first();
    t_read_again();
    t_write_dirty();
    t_read_only();
    t_leaf_absent();
    t_dir_absent();
    t_root_change();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule